// File: doc/BRIEF.md
# Block-to-Raster Line Formatter

This block turns a stream of decoded 8x8 sample blocks into raster video. Blocks arrive one sample per cycle with a tag that says whether the sample is luma, blue-difference or red-difference chroma. They are written into a slice-assembly store that is one macroblock row tall, sixteen luma lines, with one memory bank per line. When a whole slice has been written, the store is read out line by line as 8-bit 4:2:2 samples. Each line is wrapped in BT.656 start-of-active-video and end-of-active-video timing reference codes.

Each bank is released to the writer as soon as its line has been read. Blocks of the next slice are therefore accepted while the current slice is still being shown, and no second slice-sized buffer is needed. The slice width is the parameter `MB_W`, counted in macroblocks. Blanking and field timing are left to the surrounding logic, so the F and V bits of every code are zero.

Top module: `blk2raster_656`

## Requirements
- R1: During and immediately after reset, `out_valid` is low and `in_ready` is high.
- R2: Every output line is 2*16*MB_W + 8 bytes long. It is FF 00 00 XY, then the active bytes, then FF 00 00 XY, where XY = {1, F, V, H, V^H, F^H, F^V, F^V^H} with F = V = 0. H is 0 in the leading code (0x80) and 1 in the trailing code (0x9D).
- R3: Active byte 4i carries Cb of chroma column i, 4i+1 carries Y of pixel 2i, 4i+2 carries Cr of column i, and 4i+3 carries Y of pixel 2i+1.
- R4: Input order. Macroblocks arrive left to right. Each macroblock sends four luma blocks (tag 0) in the order top-left, top-right, bottom-left, bottom-right, then one Cb block (tag 1) and one Cr block (tag 2). Each block has 64 samples in row-major order. Tag 3 is illegal.
- R5: Luma row y of the slice (0 to 15) appears in output line y of that slice.
- R6: Chroma row r (0 to 7) appears in both output lines 2r and 2r+1.
- R7: The first line of a slice starts only after the last sample of that slice has been accepted. Lines 0 to 15 follow in order, and within a slice they come back to back with no idle cycle between them.
- R8: `in_ready` is low exactly when a bank the current sample targets still holds an unread line. For chroma samples these are the banks of lines 2r and 2r+1. A bank becomes writable as soon as its own line has been read. The first block of the next slice is therefore taken in before the current slice's last line starts.
- R9: While no complete slice has been written, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted this cycle when high with in_valid |
| in_comp | input | 2 | Component tag: 0 luma, 1 Cb, 2 Cr |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | BT.656 byte stream |

## Verification
Slices are driven with a coordinate hash in which every sample value depends on its component, row and column. This pattern separates errors in luma quadrant placement, chroma row replication and Cb/Y/Cr interleave. A flat slice, with one constant value per component, isolates component-lane swaps from address errors. Back-to-back slices with zero, one and two idle cycles between samples show whether stalls land on the right banks and whether early bank release lets the next slice's first block in before the last line of the current slice. A lone block followed by silence, and a reset in mid-slice, show that no partial slice is ever emitted.

// File: rtl/blk2r_pkg.sv
package blk2r_pkg;
   localparam int SLICE_LINES = 16;
   localparam int BLK_SAMPLES = 64;

   typedef enum logic [1:0] {
      COMP_Y  = 2'd0,
      COMP_CB = 2'd1,
      COMP_CR = 2'd2
   } comp_e;

   // Timing reference status word with its protection bits.
   function automatic logic [7:0] trs_xy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction
endpackage

// File: rtl/blk2r_line_bank.sv
module blk2r_line_bank #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/blk2r_writer.sv
module blk2r_writer
   import blk2r_pkg::*;
#(
   parameter int MB_W = 2,
   parameter int AW   = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [1:0]             in_comp,
   input  logic [7:0]             in_data,
   input  logic [SLICE_LINES-1:0] bank_full,
   output logic                   in_ready,
   output logic                   wr_en_a,
   output logic [3:0]             wr_line_a,
   output logic                   wr_en_b,
   output logic [3:0]             wr_line_b,
   output logic [AW-1:0]          wr_addr,
   output logic [7:0]             wr_data,
   output logic                   slice_done
);
   localparam int W     = 16 * MB_W;
   localparam int MB_CW = (MB_W > 1) ? $clog2(MB_W) : 1;
   localparam logic [AW-1:0] CB_BASE = AW'(W);
   localparam logic [AW-1:0] CR_BASE = AW'(W + W / 2);

   logic [5:0]       samp;
   logic [1:0]       lidx;
   logic [MB_CW-1:0] mb;
   logic [2:0]       row, col;
   logic             chroma, fire, mb_last;

   assign row     = samp[5:3];
   assign col     = samp[2:0];
   assign chroma  = (in_comp != COMP_Y);
   assign mb_last = (mb == MB_CW'(MB_W - 1));

   always_comb begin
      wr_line_a = chroma ? {row, 1'b0} : {lidx[1], row};
      wr_line_b = {row, 1'b1};
      unique case (in_comp)
         COMP_CB: wr_addr = CB_BASE + AW'({mb, col});
         COMP_CR: wr_addr = CR_BASE + AW'({mb, col});
         default: wr_addr = AW'({mb, lidx[0], col});
      endcase
   end

   assign in_ready   = !bank_full[wr_line_a] && (!chroma || !bank_full[wr_line_b]);
   assign fire       = in_valid && in_ready;
   assign wr_en_a    = fire;
   assign wr_en_b    = fire && chroma;
   assign wr_data    = in_data;
   assign slice_done = fire && (samp == 6'd63) && (in_comp == COMP_CR) && mb_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp <= '0;
         lidx <= '0;
         mb   <= '0;
      end else if (fire) begin
         samp <= samp + 6'd1;
         if (samp == 6'd63) begin
            if (in_comp == COMP_Y) lidx <= lidx + 2'd1;
            if (in_comp == COMP_CR) mb <= mb_last ? '0 : mb + MB_CW'(1);
         end
      end
   end

   // R4: the tag value 3 is never presented
   a_r4_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_comp != 2'd3));
endmodule

// File: rtl/blk2r_reader.sv
module blk2r_reader
   import blk2r_pkg::*;
#(
   parameter int MB_W = 2,
   parameter int AW   = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SLICE_LINES-1:0] bank_full,
   output logic [AW-1:0]          rd_addr,
   output logic [SLICE_LINES-1:0] line_clr,
   output logic [3:0]             rd_line_q,
   output logic                   out_valid,
   output logic                   out_sel_mem,
   output logic [7:0]             out_code
);
   localparam int W          = 16 * MB_W;
   localparam int LINE_BYTES = 2 * W + 8;
   localparam int PW         = $clog2(LINE_BYTES);
   localparam int ACT_END    = 4 + 2 * W;
   localparam logic [AW-1:0] CB_BASE = AW'(W);
   localparam logic [AW-1:0] CR_BASE = AW'(W + W / 2);

   logic [PW-1:0] pos, j, eav_idx;
   logic [3:0]    line;
   logic          busy, s0_valid, s0_mem, in_sav;
   logic [1:0]    code_idx;
   logic [7:0]    code_byte;

   assign s0_valid = busy || bank_full[line];
   assign in_sav   = (pos < PW'(4));
   assign s0_mem   = !in_sav && (pos < PW'(ACT_END));
   assign j        = pos - PW'(4);
   assign eav_idx  = pos - PW'(ACT_END);

   always_comb begin
      unique case (j[1:0])
         2'd0:    rd_addr = CB_BASE + AW'(j >> 2);
         2'd2:    rd_addr = CR_BASE + AW'(j >> 2);
         default: rd_addr = AW'(j >> 1);
      endcase
      code_idx = in_sav ? pos[1:0] : eav_idx[1:0];
      unique case (code_idx)
         2'd0:    code_byte = 8'hFF;
         2'd3:    code_byte = trs_xy(1'b0, 1'b0, !in_sav);
         default: code_byte = 8'h00;
      endcase
      line_clr = (s0_valid && pos == PW'(ACT_END - 1)) ? (SLICE_LINES'(1) << line) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos         <= '0;
         line        <= '0;
         busy        <= 1'b0;
         out_valid   <= 1'b0;
         out_sel_mem <= 1'b0;
         out_code    <= '0;
         rd_line_q   <= '0;
      end else begin
         out_valid   <= s0_valid;
         out_sel_mem <= s0_mem;
         out_code    <= code_byte;
         rd_line_q   <= line;
         if (s0_valid) begin
            if (pos == PW'(LINE_BYTES - 1)) begin
               pos  <= '0;
               line <= line + 4'd1;
               busy <= 1'b0;
            end else begin
               pos  <= pos + PW'(1);
               busy <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/blk2raster_656.sv
module blk2raster_656
   import blk2r_pkg::*;
#(
   parameter int MB_W = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [1:0] in_comp,
   input  logic [7:0] in_data,
   output logic       out_valid,
   output logic [7:0] out_data
);
   localparam int W     = 16 * MB_W;
   localparam int DEPTH = 2 * W;
   localparam int AW    = $clog2(DEPTH);

   if (MB_W < 1) begin : g_bad_width
      $error("MB_W must be at least 1");
   end

   logic [SLICE_LINES-1:0] bank_full, line_clr;
   logic                   wr_en_a, wr_en_b, slice_done, out_sel_mem;
   logic [3:0]             wr_line_a, wr_line_b, rd_line_q;
   logic [AW-1:0]          wr_addr, rd_addr;
   logic [7:0]             wr_data, out_code;
   logic [7:0]             bank_q [SLICE_LINES];

   blk2r_writer #(.MB_W(MB_W), .AW(AW)) u_writer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_comp(in_comp),
      .in_data(in_data), .bank_full(bank_full), .in_ready(in_ready),
      .wr_en_a(wr_en_a), .wr_line_a(wr_line_a), .wr_en_b(wr_en_b),
      .wr_line_b(wr_line_b), .wr_addr(wr_addr), .wr_data(wr_data),
      .slice_done(slice_done)
   );

   blk2r_reader #(.MB_W(MB_W), .AW(AW)) u_reader (
      .clk(clk), .rst_n(rst_n), .bank_full(bank_full), .rd_addr(rd_addr),
      .line_clr(line_clr), .rd_line_q(rd_line_q), .out_valid(out_valid),
      .out_sel_mem(out_sel_mem), .out_code(out_code)
   );

   for (genvar b = 0; b < SLICE_LINES; b++) begin : g_bank
      logic we;
      assign we = (wr_en_a && wr_line_a == 4'(b)) || (wr_en_b && wr_line_b == 4'(b));
      blk2r_line_bank #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_bank (
         .clk(clk), .we(we), .waddr(wr_addr), .wdata(wr_data),
         .raddr(rd_addr), .rdata(bank_q[b])
      );
   end

   // A bank is filled when a slice completes and released once its line is read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_full <= '0;
      else if (slice_done) bank_full <= '1;
      else                 bank_full <= bank_full & ~line_clr;
   end

   assign out_data = out_sel_mem ? bank_q[rd_line_q] : out_code;

   // R8: the reader releases only banks that hold an unread line
   a_r8_clear_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      (line_clr & ~bank_full) == '0);

   // R8: a slice can complete only once every bank of the previous one is read
   a_r8_done_all_free: assert property (@(posedge clk) disable iff (!rst_n)
      slice_done |-> (bank_full == '0));

   // R2: every line opens with the FF preamble byte
   a_r2_line_starts_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_data == 8'hFF));

   // R9: nothing is emitted while no slice is held
   a_r9_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bank_full) == '0 && bank_full == '0 && !$past(out_valid)) |-> !out_valid);
endmodule

// File: tb/blk2raster_656_tb_top.sv
`timescale 1ns/1ps
module blk2raster_656_tb_top;
   localparam int MB_W = 2;
   localparam int W    = 16 * MB_W;
   localparam int L    = 2 * W + 8;
   localparam int NV   = 4;
   // {seed[15:8], idle cycles between samples[7:4], flat pattern[0]}
   localparam logic [15:0] VEC [NV] = '{16'h1100, 16'h5A20, 16'h0001, 16'hC310};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [1:0] in_comp = '0;
   logic [7:0] in_data = '0;
   logic       out_valid;
   logic [7:0] out_data;

   int  cyc = 0;
   int  nchk = 0;
   int  nfail = 0;
   bit  finished = 1'b0;
   int  last_acc [NV];
   int  blk0_done [NV];
   bit  first_stall [NV];
   int  line0_start [NV];
   int  line15_start [NV];
   int  acc_cyc;

   blk2raster_656 #(.MB_W(MB_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_comp(in_comp), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pix(input int k, input int comp, input int y, input int x);
      logic [7:0] seed;
      seed = VEC[k][15:8];
      if (VEC[k][0]) return (comp == 0) ? 8'h10 : (comp == 1) ? 8'h80 : 8'hF0;
      return 8'(int'(seed) + comp * 85 + y * 29 + x * 7);
   endfunction

   task automatic send_sample(input int comp, input logic [7:0] d, input int gap, output bit stalled);
      @(negedge clk);
      in_valid = 1'b1;
      in_comp  = 2'(comp);
      in_data  = d;
      #1;
      stalled = !in_ready;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      acc_cyc  = cyc;
      in_valid = 1'b0;
      repeat (gap) @(posedge clk);
   endtask

   task automatic send_slice(input int k);
      bit st;
      int gap;
      gap = int'(VEC[k][7:4]);
      for (int mb = 0; mb < MB_W; mb++) begin
         for (int blk = 0; blk < 6; blk++) begin
            for (int s = 0; s < 64; s++) begin
               int comp, y, x;
               if (blk < 4) begin
                  comp = 0;
                  y = (blk / 2) * 8 + s / 8;
                  x = mb * 16 + (blk % 2) * 8 + s % 8;
               end else begin
                  comp = blk - 3;
                  y = s / 8;
                  x = mb * 8 + s % 8;
               end
               send_sample(comp, pix(k, comp, y, x), gap, st);
               if (mb == 0 && blk == 0 && s == 0) first_stall[k] = st;
               if (mb == 0 && blk == 0 && s == 63) blk0_done[k] = acc_cyc;
            end
         end
      end
      last_acc[k] = acc_cyc;
   endtask

   task automatic run_monitor();
      logic [7:0] lb [L];
      for (int k = 0; k < NV; k++) begin
         for (int n = 0; n < 16; n++) begin
            int idle, drops, bad, first_bad, act_v, exp_v;
            idle = 0;
            drops = 0;
            @(negedge clk);
            while (!out_valid) begin
               idle++;
               @(negedge clk);
            end
            if (n == 0) line0_start[k] = cyc;
            if (n == 15) line15_start[k] = cyc;
            lb[0] = out_data;
            for (int i = 1; i < L; i++) begin
               @(negedge clk);
               if (!out_valid) drops++;
               lb[i] = out_data;
            end
            // R2 framing codes
            chk(lb[0] == 8'hFF && lb[1] == 8'h00 && lb[2] == 8'h00 && lb[3] == 8'h80,
                "R2", "leading code", {lb[0], lb[1], lb[2], lb[3]}, 32'hFF000080);
            chk(lb[L-4] == 8'hFF && lb[L-3] == 8'h00 && lb[L-2] == 8'h00 && lb[L-1] == 8'h9D,
                "R2", "trailing code", {lb[L-4], lb[L-3], lb[L-2], lb[L-1]}, 32'hFF00009D);
            // R3 R4 R5 R6 active sample content
            bad = 0; first_bad = -1; act_v = 0; exp_v = 0;
            for (int jj = 0; jj < 2 * W; jj++) begin
               logic [7:0] e;
               unique case (jj % 4)
                  0: e = pix(k, 1, n / 2, jj / 4);
                  2: e = pix(k, 2, n / 2, jj / 4);
                  default: e = pix(k, 0, n, jj / 2);
               endcase
               if (lb[4 + jj] !== e) begin
                  if (first_bad < 0) begin
                     first_bad = jj; act_v = int'(lb[4 + jj]); exp_v = int'(e);
                  end
                  bad++;
               end
            end
            chk(bad == 0, "R3 R4 R5 R6", $sformatf("slice %0d line %0d byte %0d", k, n, first_bad), act_v, exp_v);
            // R7 lines back to back
            chk(drops == 0 && (n == 0 || idle == 0), "R7",
                $sformatf("slice %0d line %0d idle/drop cycles", k, n), idle + drops, 0);
         end
      end
   endtask

   task automatic main_seq();
      bit st;
      int seen;
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset state", {out_valid, in_ready}, 2'b01);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after reset release", {out_valid, in_ready}, 2'b01);

      fork
         for (int k = 0; k < NV; k++) send_slice(k);
         run_monitor();
      join

      for (int k = 0; k < NV; k++) begin
         chk(line0_start[k] > last_acc[k], "R7", $sformatf("slice %0d starts after last input", k),
             line0_start[k], last_acc[k] + 1);
         if (k > 0) begin
            chk(first_stall[k] == 1'b1, "R8", $sformatf("slice %0d first sample stalls on unread line", k),
                int'(first_stall[k]), 1);
            chk(blk0_done[k] < line15_start[k-1], "R8",
                $sformatf("slice %0d first block taken before previous line 15", k),
                blk0_done[k], line15_start[k-1]);
         end
      end

      // R9: a lone block never produces output
      for (int s = 0; s < 64; s++) send_sample(0, 8'(s), 0, st);
      seen = 0;
      repeat (400) begin
         @(negedge clk);
         if (out_valid) seen++;
      end
      chk(seen == 0, "R9", "output cycles with partial slice", seen, 0);

      // R1: reset in mid-slice
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset mid-slice", {out_valid, in_ready}, 2'b01);
      @(negedge clk);
      rst_n = 1'b1;
      finished = 1'b1;
   endtask

   initial begin
      fork
         main_seq();
         begin
            while (!finished && cyc < 150000) @(posedge clk);
            if (!finished) chk(1'b0, "watchdog", "run did not complete", cyc, 150000);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule